// File: doc/BRIEF.md
# DRAM Row Refresh Age Monitor

This block watches the access stream of a memory bus and tracks, for every row of a dynamic memory array, how many clock cycles have passed since that row was last opened. Each access with a valid strobe counts as a refresh of the row selected by the low address bits. The type of access does not matter: instruction fetch, data read or write, or a dedicated refresh cycle all count. This lets a system check whether software that runs with the refresh timer switched off still touches every row often enough.

The number of row address bits and the retention limit both follow from a density parameter. Density 0 has 128 rows, density 1 has 256 rows and density 2 has 512 rows. Each density has its own retention limit, given in clock cycles. A scanner visits one row per clock in round-robin order. When it finds a row whose age exceeds the limit, it emits a one-cycle warning, sets a sticky error flag and records the row number.

Top module: `dram_row_age_mon`

## Requirements
- R1: An access with `acc_valid_i` high refreshes the row `acc_addr_i[ROW_W-1:0]`. Address bits above the row field have no effect.
- R2: With DENSITY 0, ROW_W is 7 (128 rows) and the limit is RET_D0 cycles.
- R3: With DENSITY 1, ROW_W is 8 (256 rows) and the limit is RET_D1 cycles.
- R4: With DENSITY 2, ROW_W is 9 (512 rows) and the limit is RET_D2 cycles.
- R5: A cycle counter t starts at 0 after reset. In cycle t the scanner examines row t mod ROWS. If that row's age (t minus the cycle of its last access, or minus 0 if it has never been accessed) is strictly greater than the limit, `warn_o` is high for exactly the next cycle.
- R6: A row that has warned does not warn again until it has been accessed and has then expired again. This holds however long the bus stays idle, including across counter wraparound.
- R7: `err_o` is set by every warning and stays high until `err_clear_i` is sampled high in a cycle that produces no new warning. A warning in the same cycle as a clear leaves `err_o` high.
- R8: `err_row_o` holds the row of the first warning since reset or since the last clear, and does not change while `err_o` stays set.
- R9: Reset clears all row ages to zero and drives `warn_o` and `err_o` low. No warning occurs within the first limit+1 cycles after reset.
- R10: If a row is accessed in the same cycle in which the scanner examines it, that row does not warn in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Access strobe, one access per cycle |
| acc_addr_i | input | ADDR_W | Byte address of the access |
| err_clear_i | input | 1 | Clears the sticky error flag |
| warn_o | output | 1 | One-cycle pulse when a row is found expired |
| err_o | output | 1 | Sticky decay error flag |
| err_row_o | output | ROW_W | First expired row since the last clear |

## Verification
The embedded properties check the following on every cycle: the scanner steps through the rows in order, the error flag stays set and the captured row stays stable until a clear, a clear drops the flag, no row expires before the limit has elapsed since reset, and a same-cycle access suppresses that row's warning. The exact cycle of each warning, the row that is reported, the fact that a row warns only once per episode across counter wraparound, and the independence from upper address bits depend on the whole access history. Only the bench's reference model can show these, by running sweeps over all three densities side by side.

// File: rtl/dram_age_pkg.sv
package dram_age_pkg;

  function automatic int unsigned row_bits_f(input int unsigned dens);
    return 7 + dens;
  endfunction

  function automatic int unsigned limit_f(input int unsigned dens, input int unsigned l0,
                                         input int unsigned l1, input int unsigned l2);
    return (dens == 0) ? l0 : ((dens == 1) ? l1 : l2);
  endfunction

  // room for limit plus one full scan pass, plus one bit of margin
  function automatic int unsigned cnt_bits_f(input int unsigned limit, input int unsigned rows);
    return $clog2(limit + rows + 2) + 1;
  endfunction

endpackage

// File: rtl/row_stamp_store.sv
module row_stamp_store #(
  parameter int unsigned ROW_W = 7,
  parameter int unsigned CNT_W = 16,
  localparam int unsigned ROWS = 1 << ROW_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [ROW_W-1:0] wr_row_i,
  input  logic [CNT_W-1:0] wr_stamp_i,
  input  logic             mark_i,
  input  logic [ROW_W-1:0] rd_row_i,
  output logic [CNT_W-1:0] rd_stamp_o,
  output logic             rd_expired_o
);

  logic [CNT_W-1:0] stamp_q [ROWS];
  logic             exp_q   [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stamp_q[r] <= '0;
        exp_q[r]   <= 1'b0;
      end else if (wr_en_i && wr_row_i == ROW_W'(r)) begin
        stamp_q[r] <= wr_stamp_i;
        exp_q[r]   <= 1'b0;
      end else if (mark_i && rd_row_i == ROW_W'(r)) begin
        exp_q[r]   <= 1'b1;
      end
    end
  end

  assign rd_stamp_o   = stamp_q[rd_row_i];
  assign rd_expired_o = exp_q[rd_row_i];

  // a row being refreshed must never be marked expired in the same cycle
  assert_mark_vs_refresh_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mark_i && wr_en_i && (wr_row_i == rd_row_i)));

endmodule

// File: rtl/age_scanner.sv
module age_scanner #(
  parameter int unsigned ROW_W = 7,
  parameter int unsigned CNT_W = 16,
  parameter int unsigned LIMIT = 9545
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] stamp_i,
  input  logic             expired_i,
  input  logic             same_row_acc_i,
  output logic [ROW_W-1:0] scan_row_o,
  output logic [CNT_W-1:0] now_o,
  output logic             hit_o
);

  logic [ROW_W-1:0] scan_q;
  logic [CNT_W-1:0] now_q;
  logic [CNT_W-1:0] age;
  logic [CNT_W-1:0] boot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scan_q <= '0;
      now_q  <= '0;
    end else begin
      scan_q <= scan_q + 1'b1;
      now_q  <= now_q + 1'b1;
    end
  end

  // saturating cycles-since-reset, used by the startup property
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        boot_q <= '0;
    else if (boot_q <= CNT_W'(LIMIT))   boot_q <= boot_q + 1'b1;
  end

  assign age        = now_q - stamp_i;
  assign hit_o      = !expired_i && !same_row_acc_i && (age > CNT_W'(LIMIT));
  assign scan_row_o = scan_q;
  assign now_o      = now_q;

  assert_scan_round_robin_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> scan_row_o == ROW_W'($past(scan_row_o) + 1'b1));

  assert_no_early_expiry_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boot_q <= CNT_W'(LIMIT)) |-> !hit_o);

endmodule

// File: rtl/decay_err_track.sv
module decay_err_track #(
  parameter int unsigned ROW_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic             clear_i,
  output logic             warn_o,
  output logic             err_o,
  output logic [ROW_W-1:0] err_row_o
);

  logic             warn_q, err_q;
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      warn_q <= 1'b0;
      err_q  <= 1'b0;
      row_q  <= '0;
    end else begin
      warn_q <= hit_i;
      if (hit_i) begin
        err_q <= 1'b1;
        if (!err_q || clear_i) row_q <= row_i;
      end else if (clear_i) begin
        err_q <= 1'b0;
      end
    end
  end

  assign warn_o    = warn_q;
  assign err_o     = err_q;
  assign err_row_o = row_q;

  assert_err_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !clear_i) |=> err_o);

  assert_clear_drops_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && !hit_i) |=> !err_o);

  assert_warn_implies_err_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warn_o |-> err_o);

  assert_row_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !clear_i) |=> $stable(err_row_o));

endmodule

// File: rtl/dram_row_age_mon.sv
module dram_row_age_mon
  import dram_age_pkg::*;
#(
  parameter int unsigned DENSITY = 0,
  parameter int unsigned ADDR_W  = 20,
  parameter int unsigned RET_D0  = 9545,
  parameter int unsigned RET_D1  = 19090,
  parameter int unsigned RET_D2  = 38180,
  localparam int unsigned ROW_W  = row_bits_f(DENSITY)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              err_clear_i,
  output logic              warn_o,
  output logic              err_o,
  output logic [ROW_W-1:0]  err_row_o
);

  localparam int unsigned ROWS  = 1 << ROW_W;
  localparam int unsigned LIMIT = limit_f(DENSITY, RET_D0, RET_D1, RET_D2);
  localparam int unsigned CNT_W = cnt_bits_f(LIMIT, ROWS);

  logic [ROW_W-1:0] acc_row, scan_row;
  logic [CNT_W-1:0] now, stamp;
  logic             expired, hit, same_row;
  logic             unused_hi_bits;

  assign acc_row        = acc_addr_i[ROW_W-1:0];
  assign unused_hi_bits = ^acc_addr_i[ADDR_W-1:ROW_W];
  assign same_row       = acc_valid_i && (acc_row == scan_row);

  row_stamp_store #(.ROW_W(ROW_W), .CNT_W(CNT_W)) u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (acc_valid_i),
    .wr_row_i     (acc_row),
    .wr_stamp_i   (now),
    .mark_i       (hit),
    .rd_row_i     (scan_row),
    .rd_stamp_o   (stamp),
    .rd_expired_o (expired)
  );

  age_scanner #(.ROW_W(ROW_W), .CNT_W(CNT_W), .LIMIT(LIMIT)) u_scan (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .stamp_i        (stamp),
    .expired_i      (expired),
    .same_row_acc_i (same_row),
    .scan_row_o     (scan_row),
    .now_o          (now),
    .hit_o          (hit)
  );

  decay_err_track #(.ROW_W(ROW_W)) u_track (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hit_i     (hit),
    .row_i     (scan_row),
    .clear_i   (err_clear_i),
    .warn_o    (warn_o),
    .err_o     (err_o),
    .err_row_o (err_row_o)
  );

  assert_same_cycle_refresh_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_row == scan_row) |=> !warn_o);

endmodule

// File: tb/dram_row_age_mon_bench.sv
`timescale 1ns/1ps
module dram_row_age_mon_bench;

  localparam int AW = 20;
  localparam int L0 = 300;
  localparam int L1 = 600;
  localparam int L2 = 1200;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          acc_v = 1'b0;
  logic          clr = 1'b0;
  logic [AW-1:0] addr = '0;

  int          checks = 0;
  int          fails  = 0;
  int unsigned cyc    = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cyc <= 0;
    else         cyc <= cyc + 1;
  end

  task automatic chk(input bit ok, input string req, input int g,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s den%0d cyc=%0d actual=%0d expected=%0d", req, g, cyc, act, exp);
    end
  endtask

  for (genvar g = 0; g < 3; g++) begin : g_den
    localparam int RW  = 7 + g;
    localparam int NR  = 1 << RW;
    localparam int LIM = (g == 0) ? L0 : ((g == 1) ? L1 : L2);

    logic          warn, err;
    logic [RW-1:0] erow;

    dram_row_age_mon #(.DENSITY(g), .ADDR_W(AW), .RET_D0(L0), .RET_D1(L1), .RET_D2(L2))
    u_dram_row_age_mon (
      .clk_i       (clk),
      .rst_ni      (rst_ni),
      .acc_valid_i (acc_v),
      .acc_addr_i  (addr),
      .err_clear_i (clr),
      .warn_o      (warn),
      .err_o       (err),
      .err_row_o   (erow)
    );

    // reference model written from the requirements
    int unsigned mlast [NR];
    bit          mexp  [NR];
    bit          mwarn, merr;
    int unsigned mrow, mptr, mnow;

    always @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int r = 0; r < NR; r++) begin
          mlast[r] = 0;
          mexp[r]  = 1'b0;
        end
        mwarn = 1'b0; merr = 1'b0; mrow = 0; mptr = 0; mnow = 0;
      end else begin
        bit hit;
        int unsigned arow;
        arow = int'(addr) % NR;
        hit  = !mexp[mptr] && !(acc_v && arow == mptr) && ((mnow - mlast[mptr]) > LIM);
        mwarn = hit;
        if (acc_v) begin
          mlast[arow] = mnow;
          mexp[arow]  = 1'b0;
        end
        if (hit) mexp[mptr] = 1'b1;
        if (clr) merr = 1'b0;
        if (hit) begin
          if (!merr) mrow = mptr;
          merr = 1'b1;
        end
        mptr = (mptr + 1) % NR;
        mnow = mnow + 1;
      end
    end

    always @(negedge clk) begin
      if (rst_ni && !finished) begin
        chk(warn == mwarn, "R5/R6 warn", g, warn, mwarn);
        chk(err == merr, "R7 err", g, err, merr);
        if (merr) chk(int'(erow) == mrow, "R8 row", g, erow, mrow);
      end
    end
  end

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst_ni = 1'b0;
    wait_cycles(3);
    // R9 reset state
    chk(g_den[0].err == 0 && g_den[0].warn == 0, "R9 reset", 0, g_den[0].err, 0);
    chk(g_den[1].err == 0 && g_den[1].warn == 0, "R9 reset", 1, g_den[1].err, 0);
    chk(g_den[2].err == 0 && g_den[2].warn == 0, "R9 reset", 2, g_den[2].err, 0);
    rst_ni = 1'b1;

    // R9: quiet through the smallest limit
    wait_cycles(300);
    chk(g_den[0].err == 0, "R9 no early warn", 0, g_den[0].err, 0);

    // idle until every row of every density has expired
    wait_cycles(1800);
    chk(g_den[0].err == 1 && g_den[0].erow == 7'd45,  "R2 first row", 0, g_den[0].erow, 45);
    chk(g_den[1].err == 1 && g_den[1].erow == 8'd89,  "R3 first row", 1, g_den[1].erow, 89);
    chk(g_den[2].err == 1 && g_den[2].erow == 9'd177, "R4 first row", 2, g_den[2].erow, 177);

    // R7 clear
    clr = 1'b1;
    wait_cycles(1);
    clr = 1'b0;
    chk(g_den[0].err == 0, "R7 clear", 0, g_den[0].err, 0);
    chk(g_den[2].err == 0, "R7 clear", 2, g_den[2].err, 0);

    // R10: refresh row 5 once, then again exactly when it is scanned while stale
    begin
      int unsigned t5;
      acc_v = 1'b1; addr = 20'h5A005;
      t5 = cyc;
      wait_cycles(1);
      acc_v = 1'b0;
      while (!((cyc % 128) == 5 && (cyc - t5) > 300)) wait_cycles(1);
      acc_v = 1'b1; addr = 20'hC3205;
      wait_cycles(1);
      acc_v = 1'b0;
      wait_cycles(3);
      chk(g_den[0].err == 0, "R10 same-cycle refresh", 0, g_den[0].err, 0);
    end

    // R1: full sweep of 512 rows with random upper bits keeps all densities alive
    for (int i = 0; i < 3000; i++) begin
      acc_v = 1'b1;
      addr  = {11'($urandom), 9'(i % 512)};
      wait_cycles(1);
    end
    chk(g_den[0].err == 0, "R1 sweep", 0, g_den[0].err, 0);
    chk(g_den[1].err == 0, "R1 sweep", 1, g_den[1].err, 0);
    chk(g_den[2].err == 0, "R1 sweep", 2, g_den[2].err, 0);

    // R1/R3: only 128 rows touched, upper address bits random
    for (int i = 0; i < 3000; i++) begin
      acc_v = 1'b1;
      addr  = {11'($urandom), 2'b00, 7'(i % 128)};
      wait_cycles(1);
    end
    chk(g_den[0].err == 0, "R1 upper bits ignored", 0, g_den[0].err, 0);
    chk(g_den[1].err == 1 && g_den[1].erow >= 8'd128, "R3 upper rows decay", 1, g_den[1].erow, 128);
    chk(g_den[2].err == 1, "R4 upper rows decay", 2, g_den[2].err, 1);

    // random traffic with occasional clears
    for (int i = 0; i < 8000; i++) begin
      acc_v = ($urandom % 4) != 0;
      addr  = 20'($urandom);
      clr   = ($urandom % 200) == 0;
      wait_cycles(1);
    end
    acc_v = 1'b0;
    clr   = 1'b0;

    // R6: long idle, counters wrap many times; model checks single warnings
    clr = 1'b1;
    wait_cycles(1);
    clr = 1'b0;
    wait_cycles(30000);
    chk(g_den[0].err == 1, "R6 idle decay", 0, g_den[0].err, 1);
    chk(g_den[2].err == 1, "R6 idle decay", 2, g_den[2].err, 1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule